// File: doc/BRIEF.md
# Standby Rail Power-Up Sequencer

This block is a clocked state machine that takes a platform's always-on rail group from fully off to a standby state and back down again. On a power-up request it enables the 5 V rail, then the 3.3 V rail group, then the 1.8 V rail. Before each next step it waits for that stage's readiness indication: a digital power-good for the 5 V rail, a single-bit threshold comparator for the 3.3 V group (asserted when the rail is at or above 3000 mV), and both the 1.8 V and 1.05 V power-goods for the last stage. The 1.05 V good also vouches for the core primary rail, which is chain-enabled by the regulators themselves.

Once every standby rail is good, the block waits a settle interval of at least 10 ms and then releases the active-low reset to the platform controller hub. Every wait is bounded by a 1 s timeout. A timeout, a shutdown request, or the loss of any standby good while settling or in standby starts the same ordered power-down. Reset is pulled low first, and it is held for at least 1 us. The rail enables then fall in the reverse of their power-up order. All asynchronous inputs pass through two-flop synchronizers. The three time intervals are cycle counts of one shared counter, derived from a clock-frequency parameter.

Top module: `stby_rail_seq`

## Requirements
- R1: After reset, seqState is 0 (off), en5v, en33 and en18 are low, hubRstN is low and timeoutFault is low.
- R2: State codes are 0 off, 1 wait-5V, 2 wait-3.3V, 3 wait-1.8V/1.05V, 4 settle, 5 standby, 6 reset-hold, 7 1.8V-dropped, 8 3.3V-dropped, 9 5V-dropped. A high upReq in state 0 enables en5v and enters state 1. en33 turns on only after pg5v has been seen high. en18 turns on only after v33AboveMin has been seen high.
- R3: State 3 is left only when pg18 and pg105 are both high. Either one alone does not advance the sequence.
- R4: hubRstN goes high, and state 5 is entered, after exactly ceil(CLK_HZ/100) cycles in state 4 with all goods held high. hubRstN is never high while en18 is low.
- R5: A wait state (1, 2 or 3) whose condition stays unmet for CLK_HZ cycles is left for state 6 with timeoutFault set. The sequence then ends in state 0.
- R6: Power-down holds hubRstN low for max(1, ceil(CLK_HZ/1e6)) cycles in state 6. It then drops en18, en33 and en5v on successive cycles, in that order, and returns to state 0.
- R7: In state 5, a low on any of pg5v, v33AboveMin, pg18 or pg105 starts the power-down and leaves timeoutFault low.
- R8: A high downReq in any of states 1 to 5 starts the power-down without setting timeoutFault.
- R9: upReq is ignored in states 6 to 9. A request pulse seen there does not restart the sequence once state 0 is reached.
- R10: timeoutFault stays set in state 0. It clears when a new power-up request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upReq | input | 1 | Power-up request, level sensitive |
| downReq | input | 1 | Shutdown request, level sensitive |
| pg5v | input | 1 | 5 V rail power-good, asynchronous |
| pg18 | input | 1 | 1.8 V rail power-good, asynchronous |
| pg105 | input | 1 | 1.05 V rail power-good, asynchronous |
| v33AboveMin | input | 1 | 3.3 V comparator output, high at or above 3000 mV |
| en5v | output | 1 | 5 V rail enable |
| en33 | output | 1 | 3.3 V rail group enable |
| en18 | output | 1 | 1.8 V rail enable |
| hubRstN | output | 1 | Active-low reset to the platform controller hub |
| seqState | output | 4 | Current sequencer state code |
| timeoutFault | output | 1 | Set by a wait timeout, cleared by the next power-up |

## Verification
The embedded properties check the rail nesting on every cycle: en33 implies en5v, en18 implies en33, and hubRstN implies en18. They also check that reset was low in the cycle before en18 falls, that the timer never passes its timeout count, that the fault rises only on entry to the reset-hold state, and that a shutdown always ends in off and never restarts part way. Only the bench scenarios can show the exact durations of the settle, timeout and reset-hold intervals. The same holds for the rule that both final goods are needed, the fault's stickiness and clearing, the response to rail loss and early shutdown requests, and the dropping of a request made during power-down.

// File: rtl/stby_seq_pkg.sv
package stby_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF    = 4'd0,
    ST_WAIT5  = 4'd1,
    ST_WAIT33 = 4'd2,
    ST_WAIT18 = 4'd3,
    ST_SETTLE = 4'd4,
    ST_STBY   = 4'd5,
    ST_SD_GAP = 4'd6,
    ST_SD_18  = 4'd7,
    ST_SD_33  = 4'd8,
    ST_SD_5   = 4'd9
  } seqState_e;

  // Strobes from control to datapath, each active for one cycle.
  typedef struct packed {
    logic tmrClr;
    logic on5;
    logic on33;
    logic on18;
    logic off5;
    logic off33;
    logic off18;
    logic hubRelease;
    logic hubHold;
  } seqStrobe_t;

  // Cycles covering 1/div seconds at hz, rounded up.
  function automatic int cyclesFor(input int hz, input int div);
    return (hz + div - 1) / div;
  endfunction

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end

endmodule

// File: rtl/stby_datapath.sv
module stby_datapath
  import stby_seq_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seqStrobe_t stb,
  output logic       en5v,
  output logic       en33,
  output logic       en18,
  output logic       hubRstN,
  output logic       settleDone,
  output logic       timeoutHit,
  output logic       gapDone
);

  localparam int TIMEOUT_CYC = CLK_HZ;
  localparam int SETTLE_CYC  = cyclesFor(CLK_HZ, 100);
  localparam int GAP_RAW     = cyclesFor(CLK_HZ, 1_000_000);
  localparam int GAP_CYC     = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int CNT_W       = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(GAP_CYC - 1);

  logic [CNT_W-1:0] cnt;

  // Single interval counter, cleared on every state change, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (stb.tmrClr) begin
      cnt <= '0;
    end else if (cnt != TMO_LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign timeoutHit = (cnt == TMO_LAST);
  assign settleDone = (cnt == SETTLE_LAST);
  assign gapDone    = (cnt == GAP_LAST);

  // Enable and reset registers, set and cleared by strobes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en5v    <= 1'b0;
      en33    <= 1'b0;
      en18    <= 1'b0;
      hubRstN <= 1'b0;
    end else begin
      if (stb.on5)        en5v    <= 1'b1;
      else if (stb.off5)  en5v    <= 1'b0;
      if (stb.on33)       en33    <= 1'b1;
      else if (stb.off33) en33    <= 1'b0;
      if (stb.on18)       en18    <= 1'b1;
      else if (stb.off18) en18    <= 1'b0;
      if (stb.hubRelease) hubRstN <= 1'b1;
      else if (stb.hubHold) hubRstN <= 1'b0;
    end
  end

  p_rail33_needs5_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en33 |-> en5v);
  p_rail18_needs33_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en18 |-> en33);
  p_hub_needs18_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hubRstN |-> en18);
  p_reset_before_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en18) |-> !$past(hubRstN));
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TMO_LAST);

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upReq,
  input  logic       downReq,
  input  logic       good5,
  input  logic       good33,
  input  logic       good18,
  input  logic       good105,
  input  logic       settleDone,
  input  logic       timeoutHit,
  input  logic       gapDone,
  output seqStrobe_t stb,
  output seqState_e  st,
  output logic       timeoutFault
);

  seqState_e nxt;
  logic      failNow;
  logic      allGood;

  assign allGood = good5 && good33 && good18 && good105;

  always_comb begin
    nxt     = st;
    stb     = '0;
    failNow = 1'b0;
    case (st)
      ST_OFF: begin
        if (upReq) begin
          nxt     = ST_WAIT5;
          stb.on5 = 1'b1;
        end
      end
      ST_WAIT5: begin
        if (downReq) begin
          nxt = ST_SD_GAP;
        end else if (good5) begin
          nxt      = ST_WAIT33;
          stb.on33 = 1'b1;
        end else if (timeoutHit) begin
          nxt     = ST_SD_GAP;
          failNow = 1'b1;
        end
      end
      ST_WAIT33: begin
        if (downReq) begin
          nxt = ST_SD_GAP;
        end else if (good33) begin
          nxt      = ST_WAIT18;
          stb.on18 = 1'b1;
        end else if (timeoutHit) begin
          nxt     = ST_SD_GAP;
          failNow = 1'b1;
        end
      end
      ST_WAIT18: begin
        if (downReq) begin
          nxt = ST_SD_GAP;
        end else if (good18 && good105) begin
          nxt = ST_SETTLE;
        end else if (timeoutHit) begin
          nxt     = ST_SD_GAP;
          failNow = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (downReq || !allGood) begin
          nxt = ST_SD_GAP;
        end else if (settleDone) begin
          nxt            = ST_STBY;
          stb.hubRelease = 1'b1;
        end
      end
      ST_STBY: begin
        if (downReq || !allGood) nxt = ST_SD_GAP;
      end
      ST_SD_GAP: begin
        if (gapDone) begin
          nxt       = ST_SD_18;
          stb.off18 = 1'b1;
        end
      end
      ST_SD_18: begin
        nxt       = ST_SD_33;
        stb.off33 = 1'b1;
      end
      ST_SD_33: begin
        nxt      = ST_SD_5;
        stb.off5 = 1'b1;
      end
      ST_SD_5: nxt = ST_OFF;
      default: nxt = ST_OFF;
    endcase
    stb.tmrClr  = (nxt != st);
    stb.hubHold = (nxt == ST_SD_GAP) && (st != ST_SD_GAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_OFF;
      timeoutFault <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_OFF && upReq) timeoutFault <= 1'b0;
      else if (failNow)          timeoutFault <= 1'b1;
    end
  end

  p_fault_at_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeoutFault) |-> st == ST_SD_GAP);
  p_shutdown_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st >= ST_SD_GAP) |=> st != ST_WAIT5);
  p_shutdown_ends_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_SD_5 |=> st == ST_OFF);
  p_off_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_OFF |=> (st == ST_OFF || st == ST_WAIT5));

endmodule

// File: rtl/stby_rail_seq.sv
module stby_rail_seq
  import stby_seq_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upReq,
  input  logic       downReq,
  input  logic       pg5v,
  input  logic       pg18,
  input  logic       pg105,
  input  logic       v33AboveMin,
  output logic       en5v,
  output logic       en33,
  output logic       en18,
  output logic       hubRstN,
  output logic [3:0] seqState,
  output logic       timeoutFault
);

  logic [3:0] goodSync;
  seqStrobe_t stb;
  seqState_e  st;
  logic       settleDone;
  logic       timeoutHit;
  logic       gapDone;

  stby_sync #(.WIDTH(4)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({pg105, pg18, v33AboveMin, pg5v}),
    .syncOut (goodSync)
  );

  stby_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .upReq        (upReq),
    .downReq      (downReq),
    .good5        (goodSync[0]),
    .good33       (goodSync[1]),
    .good18       (goodSync[2]),
    .good105      (goodSync[3]),
    .settleDone   (settleDone),
    .timeoutHit   (timeoutHit),
    .gapDone      (gapDone),
    .stb          (stb),
    .st           (st),
    .timeoutFault (timeoutFault)
  );

  stby_datapath #(.CLK_HZ(CLK_HZ)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .en5v       (en5v),
    .en33       (en33),
    .en18       (en18),
    .hubRstN    (hubRstN),
    .settleDone (settleDone),
    .timeoutHit (timeoutHit),
    .gapDone    (gapDone)
  );

  assign seqState = st;

endmodule

// File: tb/stby_rail_seq_test.sv
module stby_rail_seq_test;

  localparam int HZ      = 10_000;
  localparam int TMO     = HZ;
  localparam int SETTLE  = (HZ + 99) / 100;
  localparam int GAPRAW  = (HZ + 999_999) / 1_000_000;
  localparam int GAP     = (GAPRAW < 1) ? 1 : GAPRAW;

  // Vector: {stall point[2:0], expected fault, expect standby}
  // stall 0 none, 1 pg5v, 2 comparator, 3 pg18, 4 pg105
  localparam logic [4:0] VEC [5] = '{
    {3'd0, 1'b0, 1'b1},
    {3'd1, 1'b1, 1'b0},
    {3'd2, 1'b1, 1'b0},
    {3'd3, 1'b1, 1'b0},
    {3'd4, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upReq = 1'b0, downReq = 1'b0;
  logic pg5v = 1'b0, pg18 = 1'b0, pg105 = 1'b0, v33AboveMin = 1'b0;
  logic en5v, en33, en18, hubRstN, timeoutFault;
  logic [3:0] seqState;

  int checks = 0, failures = 0;
  int stall = 0;
  bit drop105 = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  stby_rail_seq #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .upReq(upReq), .downReq(downReq),
    .pg5v(pg5v), .pg18(pg18), .pg105(pg105), .v33AboveMin(v33AboveMin),
    .en5v(en5v), .en33(en33), .en18(en18), .hubRstN(hubRstN),
    .seqState(seqState), .timeoutFault(timeoutFault)
  );

  // Rail model: each good follows its enable unless stalled.
  always @(posedge clk) begin
    pg5v        <= en5v && stall != 1;
    v33AboveMin <= en33 && stall != 2;
    pg18        <= en18 && stall != 3;
    pg105       <= en18 && stall != 4 && !drop105;
  end

  // Monitor: time spent per state, and ordering errors.
  int dur [16];
  int run = 0;
  logic [3:0] prevSt = 4'd0;
  int orderErr = 0;
  logic pEn5 = 0, pEn33 = 0, pEn18 = 0, pHub = 0, pPg5 = 0, pV33 = 0, pPg18 = 0, pPg105 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (seqState == prevSt) run++;
      else begin
        dur[prevSt] = run;
        run = 1;
      end
      prevSt = seqState;
      if (en33 && !pEn33 && !pPg5) orderErr++;
      if (en18 && !pEn18 && !pV33) orderErr++;
      if (hubRstN && !pHub && !(pPg18 && pPg105)) orderErr++;
      if (!en18 && pEn18 && pHub) orderErr++;
      if (!en33 && pEn33 && pEn18) orderErr++;
      if (!en5v && pEn5 && pEn33) orderErr++;
      pEn5 = en5v; pEn33 = en33; pEn18 = en18; pHub = hubRstN;
      pPg5 = pg5v; pV33 = v33AboveMin; pPg18 = pg18; pPg105 = pg105;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitState(input int code, input int bound);
    for (int k = 0; k < bound && seqState != 4'(code); k++) tick();
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
    end
  end

  initial begin
    int errBase;
    tick(3);
    // R1: reset state
    check(seqState == 0 && !en5v && !en33 && !en18 && !hubRstN && !timeoutFault,
          "R1 reset state", {seqState, en5v, en33, en18, hubRstN, timeoutFault}, 0);
    rst_n = 1'b1;
    tick(3);
    check(seqState == 0 && !en5v, "R1 idle after reset", seqState, 0);

    for (int i = 0; i < 5; i++) begin
      int waitCode;
      stall = int'(VEC[i][4:2]);
      waitCode = (stall == 4) ? 3 : stall;
      errBase = orderErr;
      upReq = 1'b1;
      waitState(1, 20);
      upReq = 1'b0;
      check(seqState == 1 && en5v, "R2 start in state 1", seqState, 1);
      check(!timeoutFault, "R10 fault cleared on start", timeoutFault, 0);
      if (VEC[i][0]) begin
        waitState(5, 500);
        check(seqState == 5 && en5v && en33 && en18, "R2 R3 reach standby", seqState, 5);
        check(hubRstN == 1'b1, "R4 reset released", hubRstN, 1);
        check(dur[4] == SETTLE, "R4 settle length", dur[4], SETTLE);
        downReq = 1'b1;
        tick();
        downReq = 1'b0;
        waitState(0, 50);
        check(seqState == 0 && !timeoutFault, "R8 request shutdown", timeoutFault, 0);
        check(dur[6] == GAP, "R6 reset hold length", dur[6], GAP);
        check(dur[7] == 1 && dur[8] == 1 && dur[9] == 1, "R6 one drop per cycle",
              dur[7] + dur[8] + dur[9], 3);
      end else begin
        waitState(0, TMO + 200);
        check(seqState == 0 && timeoutFault, "R5 timeout fault", timeoutFault, 1);
        check(dur[waitCode] == TMO, "R5 timeout length", dur[waitCode], TMO);
        check(!en5v && !en33 && !en18 && !hubRstN, "R6 all off after timeout",
              {en5v, en33, en18, hubRstN}, 0);
        if (stall == 4) check(dur[3] == TMO, "R3 pg18 alone not enough", dur[3], TMO);
        tick(20);
        check(timeoutFault && seqState == 0, "R10 fault held in off", timeoutFault, 1);
      end
      check(orderErr == errBase, "R2 R6 ordering", orderErr - errBase, 0);
      tick(5);
    end

    // R7: rail loss in standby
    stall = 0;
    errBase = orderErr;
    upReq = 1'b1;
    waitState(1, 20);
    upReq = 1'b0;
    waitState(5, 500);
    check(seqState == 5, "R7 standby reached", seqState, 5);
    drop105 = 1'b1;
    waitState(0, 50);
    check(seqState == 0 && !timeoutFault && !en5v, "R7 loss shuts down", timeoutFault, 0);
    check(orderErr == errBase, "R7 R6 ordering on loss", orderErr - errBase, 0);
    drop105 = 1'b0;
    tick(5);

    // R8: shutdown request while waiting on comparator
    stall = 2;
    upReq = 1'b1;
    waitState(1, 20);
    upReq = 1'b0;
    waitState(2, 50);
    tick(30);
    downReq = 1'b1;
    tick();
    downReq = 1'b0;
    waitState(0, 50);
    check(seqState == 0 && !timeoutFault, "R8 early shutdown no fault", timeoutFault, 0);
    check(dur[2] < TMO, "R8 left before timeout", dur[2], 31);
    stall = 0;
    tick(5);

    // R9: request during power-down is dropped
    upReq = 1'b1;
    waitState(1, 20);
    upReq = 1'b0;
    waitState(5, 500);
    downReq = 1'b1;
    tick();
    downReq = 1'b0;
    waitState(7, 50);
    check(seqState == 7, "R9 in drop stage", seqState, 7);
    upReq = 1'b1;
    tick();
    upReq = 1'b0;
    waitState(0, 50);
    tick(20);
    check(seqState == 0 && !en5v, "R9 request ignored", seqState, 0);

    finished = 1'b1;
    summary();
  end

endmodule